// File: doc/BRIEF.md
# I2C Slave Address Responder

This block is the slave half of a two-wire serial bus port. It watches a clock line and a data line for bus conditions (start and stop), shifts in the first byte after each start and compares it with a programmable own-address register. It acknowledges the bytes it accepts and hands them to the host through a single receive holding register. When the address asks for a read, it sends bytes that the host writes, most significant bit first. Both wires are open-drain: the block only ever pulls a line low or lets it float. Every decision uses pin samples that have passed through a synchronizer.

Flow control uses clock stretching. After a read address, and after each sent byte that the bus master acknowledges, the slave holds the clock line low. The host loads the next byte and then pulses a release strobe. In ten-bit addressing mode each address byte raises an address-update flag and stretches the clock. The host clears that stretch by rewriting the address register, normally with the other half of the ten-bit address. Optional general-call acceptance and an optional interrupt on every start and stop are selected by static inputs.

The controller has five named states. IDLE ignores bus clocks. ADDR_HI receives the first address byte after a start. ADDR_LO receives the second ten-bit address byte. RECV receives data bytes. SEND transmits data bytes. The transitions are:
- start to ADDR_HI, from any state.
- stop to IDLE, from any state. Clearing `enable` also returns the block to IDLE.
- mismatch at the eighth clock to IDLE, from ADDR_HI or ADDR_LO.
- ninth-clock NACK to IDLE, from any receive state.
- ADDR_HI to SEND on a read address, to ADDR_LO on a ten-bit write address, and to RECV otherwise.
- ADDR_LO to RECV.
- master NACK to IDLE, from SEND.

Top module: `i2c_addr_responder`

## Requirements
- R1: A fall of the data line while the clock line is high sets `start_seen`, clears `stop_seen` and `read_mode`, and restarts address reception from bit zero.
- R2: A rise of the data line while the clock line is high sets `stop_seen`, clears `start_seen`, returns to IDLE and releases both lines.
- R3: Bits are sampled on the clock rise. A first byte whose upper seven bits equal the upper seven bits of the address register (bit 0 = direction, 1 = read) is acknowledged: the data line is low during the ninth clock-high phase.
- R4: A first byte that does not match is not acknowledged. The slave stays idle until the next start: later bytes get no acknowledge, no interrupt and no change of `rx_data`.
- R5: The byte 0x00 is accepted as an address only when `gcall_en` is 1. It then leads to data reception.
- R6: An accepted byte is copied to `rx_data` and sets `buf_full`. At the ninth clock fall `irq` pulses for one cycle. At that point `data_not_addr` is 0 after an address byte and 1 after a data byte. `rx_rd` clears `buf_full`.
- R7: If `buf_full` or `overflow` is set when a byte completes, the byte is not acknowledged and `rx_data` is kept. If `buf_full` was set, `overflow` is set. `ovf_clr` clears `overflow`.
- R8: A matched address with bit 0 = 1 sets `read_mode`, clears `buf_full` and `clk_released`, and holds the clock line low until `clk_release` is pulsed.
- R9: In read mode, a `tx_din` byte written by `tx_wr` is presented most significant bit first. Each data change happens while the clock is low. At the ninth clock fall `irq` pulses. A master ACK stretches the clock again and sets `data_not_addr`. A master NACK returns to IDLE with both lines released.
- R10: With `ten_bit_mode` = 1, the first address byte is compared with bit 0 masked and the second in full. A read address goes to SEND as in R8. Each acknowledged address byte that is not a read sets `addr_update` and holds the clock line low. A write of the address register clears `addr_update` and releases the clock.
- R11: With `cond_irq_en` = 1, `irq` also pulses on every start and stop. With it at 0, bus conditions raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low forces IDLE with lines released |
| ten_bit_mode | input | 1 | 1 = ten-bit addressing |
| gcall_en | input | 1 | 1 = accept address 0x00 |
| cond_irq_en | input | 1 | 1 = interrupt on start and stop |
| scl_i | input | 1 | Clock line level |
| sda_i | input | 1 | Data line level |
| scl_oe | output | 1 | 1 = pull clock line low |
| sda_oe | output | 1 | 1 = pull data line low |
| own_addr_wr | input | 1 | Address register write strobe |
| own_addr_din | input | DW | Address register write data |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_din | input | DW | Transmit byte |
| rx_rd | input | 1 | Receive register read strobe (clears buf_full) |
| rx_data | output | DW | Last accepted byte |
| ovf_clr | input | 1 | Clears overflow |
| clk_release | input | 1 | Releases a read-mode clock stretch |
| buf_full | output | 1 | Holding register occupied |
| overflow | output | 1 | A byte arrived while full |
| start_seen | output | 1 | Last condition was a start |
| stop_seen | output | 1 | Last condition was a stop |
| data_not_addr | output | 1 | Last byte was data |
| read_mode | output | 1 | Current transfer is a read |
| addr_update | output | 1 | Ten-bit address register must be rewritten |
| clk_released | output | 1 | 0 while a read-mode stretch is held |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong bit count or state shows on the data line. A missing or misplaced acknowledge appears within the same ninth clock, and a lost byte alignment corrupts the next value the bus master reads. A stretch that is wrongly held or released shows within a few system cycles after the master lets the clock go: the clock line either stays low or rises. Flag and interrupt errors show in the cycle of the ninth clock fall. The scoreboard samples there, so every interrupt must match a predicted event.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_RECV,
        ST_SEND
    } slv_state_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '1;
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                stg[i] <= stg[i-1];
            end
            stg[0] <= din;
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_core.sv
module i2cs_core
    import i2cs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          ten_bit,
    input  logic          gcall_en,
    input  logic          cond_irq_en,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          sda_s,
    input  logic          addr_wr,
    input  logic [DW-1:0] addr_din,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_din,
    input  logic          rx_rd,
    input  logic          ovf_clr,
    input  logic          clk_release,
    output logic          scl_hold,
    output logic          sda_low,
    output logic [DW-1:0] rx_data,
    output logic          bf,
    output logic          ovf,
    output logic          start_f,
    output logic          stop_f,
    output logic          da,
    output logic          rw,
    output logic          ua,
    output logic          ckp,
    output logic          irq
);
    localparam int CNT_W = $clog2(DW + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(DW + 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    slv_state_e       state_q, state_d;
    logic [CNT_W-1:0] bitcnt;
    logic [DW-1:0]    shreg;
    logic [DW-1:0]    addr_reg;
    logic             hold_ckp;

    logic is_addr, is_rx, gc_hit, addr_hit, byte_end, ack_end, tx_edge, rd_req;

    assign is_addr  = (state_q == ST_ADDR_HI) || (state_q == ST_ADDR_LO);
    assign is_rx    = is_addr || (state_q == ST_RECV);
    assign gc_hit   = gcall_en && (shreg == '0) && (state_q == ST_ADDR_HI);
    assign addr_hit = (state_q == ST_ADDR_HI) ? ({shreg[DW-1:1], 1'b0} == {addr_reg[DW-1:1], 1'b0})
                                              : (shreg == addr_reg);
    assign byte_end = scl_fall && is_rx && (bitcnt == LAST_BIT);
    assign ack_end  = scl_fall && is_rx && (bitcnt == ACK_BIT);
    assign tx_edge  = scl_fall && (state_q == ST_SEND);
    assign rd_req   = (state_q == ST_ADDR_HI) && !gc_hit && shreg[0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!enable || stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR_HI;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR_HI: begin
                    if (byte_end && !(addr_hit || gc_hit)) state_d = ST_IDLE;
                    else if (ack_end) begin
                        if (sda_s)        state_d = ST_IDLE;
                        else if (gc_hit)  state_d = ST_RECV;
                        else if (shreg[0]) state_d = ST_SEND;
                        else if (ten_bit) state_d = ST_ADDR_LO;
                        else              state_d = ST_RECV;
                    end
                end
                ST_ADDR_LO: begin
                    if (byte_end && !addr_hit) state_d = ST_IDLE;
                    else if (ack_end)          state_d = sda_s ? ST_IDLE : ST_RECV;
                end
                ST_RECV: begin
                    if (ack_end && sda_s) state_d = ST_IDLE;
                end
                ST_SEND: begin
                    if (tx_edge && (bitcnt == LAST_BIT) && sda_s) state_d = ST_IDLE;
                end
            endcase
        end
    end

    // datapath, flags and pin controls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            shreg    <= '0;
            addr_reg <= '0;
            rx_data  <= '0;
            bf       <= 1'b0;
            ovf      <= 1'b0;
            start_f  <= 1'b0;
            stop_f   <= 1'b0;
            da       <= 1'b0;
            rw       <= 1'b0;
            ua       <= 1'b0;
            hold_ckp <= 1'b0;
            sda_low  <= 1'b0;
            irq      <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (addr_wr) begin
                addr_reg <= addr_din;
                ua       <= 1'b0;
            end
            if (clk_release) hold_ckp <= 1'b0;
            if (rx_rd)       bf <= 1'b0;
            if (ovf_clr)     ovf <= 1'b0;
            if (!enable) begin
                bitcnt   <= '0;
                sda_low  <= 1'b0;
                hold_ckp <= 1'b0;
                ua       <= 1'b0;
            end else if (stop_det) begin
                stop_f   <= 1'b1;
                start_f  <= 1'b0;
                rw       <= 1'b0;
                bitcnt   <= '0;
                sda_low  <= 1'b0;
                hold_ckp <= 1'b0;
                ua       <= 1'b0;
                irq      <= cond_irq_en;
            end else if (start_det) begin
                start_f  <= 1'b1;
                stop_f   <= 1'b0;
                rw       <= 1'b0;
                bitcnt   <= '0;
                shreg    <= '0;
                sda_low  <= 1'b0;
                hold_ckp <= 1'b0;
                ua       <= 1'b0;
                irq      <= cond_irq_en;
            end else if (tx_wr && (state_q == ST_SEND) && !bf) begin
                shreg   <= tx_din;
                bf      <= 1'b1;
                bitcnt  <= '0;
                sda_low <= !tx_din[DW-1];
            end else if (scl_rise && is_rx && (bitcnt < LAST_BIT)) begin
                shreg  <= {shreg[DW-2:0], sda_s};
                bitcnt <= bitcnt + ONE;
            end else if (byte_end) begin
                if (is_addr && !(addr_hit || gc_hit)) begin
                    bitcnt <= '0;
                end else begin
                    if (!bf && !ovf) begin
                        rx_data <= shreg;
                        bf      <= 1'b1;
                        sda_low <= 1'b1;
                    end else if (bf) begin
                        ovf <= 1'b1;
                    end
                    bitcnt <= ACK_BIT;
                end
            end else if (ack_end) begin
                sda_low <= 1'b0;
                bitcnt  <= '0;
                irq     <= 1'b1;
                da      <= !is_addr;
                if (!sda_s && rd_req) begin
                    rw       <= 1'b1;
                    bf       <= 1'b0;
                    hold_ckp <= 1'b1;
                end else if (!sda_s && ten_bit && is_addr && !gc_hit) begin
                    ua <= 1'b1;
                end
            end else if (tx_edge) begin
                if (bitcnt < LAST_BIT) begin
                    bitcnt <= bitcnt + ONE;
                    if (bitcnt < LAST_BIT - ONE) begin
                        shreg   <= {shreg[DW-2:0], 1'b0};
                        sda_low <= !shreg[DW-2];
                    end else begin
                        sda_low <= 1'b0;
                        bf      <= 1'b0;
                    end
                end else begin
                    irq    <= 1'b1;
                    bitcnt <= '0;
                    if (!sda_s) begin
                        da       <= 1'b1;
                        hold_ckp <= 1'b1;
                    end
                end
            end
        end
    end

    assign scl_hold = hold_ckp | ua;
    assign ckp      = !hold_ckp;

    p_start_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start_det && !stop_det) |=> (start_f && !stop_f && !rw));

    p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && stop_det) |=> (state_q == ST_IDLE && !sda_low && stop_f));

    p_no_ack_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && byte_end && (bf || ovf)) |=> !sda_low);

    p_read_stretch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rw) |-> hold_ckp);

    p_tx_sda_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND && enable && !scl_fall && !start_det && !stop_det && !tx_wr)
        |=> $stable(sda_low));
endmodule

// File: rtl/i2c_addr_responder.sv
module i2c_addr_responder #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          ten_bit_mode,
    input  logic          gcall_en,
    input  logic          cond_irq_en,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_oe,
    output logic          sda_oe,
    input  logic          own_addr_wr,
    input  logic [DW-1:0] own_addr_din,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_din,
    input  logic          rx_rd,
    output logic [DW-1:0] rx_data,
    input  logic          ovf_clr,
    input  logic          clk_release,
    output logic          buf_full,
    output logic          overflow,
    output logic          start_seen,
    output logic          stop_seen,
    output logic          data_not_addr,
    output logic          read_mode,
    output logic          addr_update,
    output logic          clk_released,
    output logic          irq
);
    logic [1:0] pins_s;
    logic       scl_rise, scl_fall, start_det, stop_det;

    i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (pins_s)
    );

    i2cs_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (pins_s[1]),
        .sda_s    (pins_s[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2cs_core #(.DW(DW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .ten_bit    (ten_bit_mode),
        .gcall_en   (gcall_en),
        .cond_irq_en(cond_irq_en),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .sda_s      (pins_s[0]),
        .addr_wr    (own_addr_wr),
        .addr_din   (own_addr_din),
        .tx_wr      (tx_wr),
        .tx_din     (tx_din),
        .rx_rd      (rx_rd),
        .ovf_clr    (ovf_clr),
        .clk_release(clk_release),
        .scl_hold   (scl_oe),
        .sda_low    (sda_oe),
        .rx_data    (rx_data),
        .bf         (buf_full),
        .ovf        (overflow),
        .start_f    (start_seen),
        .stop_f     (stop_seen),
        .da         (data_not_addr),
        .rw         (read_mode),
        .ua         (addr_update),
        .ckp        (clk_released),
        .irq        (irq)
    );

    p_ua_stretch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        addr_update |-> scl_oe);
endmodule

// File: tb/i2c_addr_responder_tb_top.sv
module i2c_addr_responder_tb_top;
    localparam int H = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, ten_bit_mode = 1'b0, gcall_en = 1'b0, cond_irq_en = 1'b0;
    logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic       scl_oe, sda_oe;
    logic       own_addr_wr = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0, ovf_clr = 1'b0, clk_release = 1'b0;
    logic [7:0] own_addr_din = '0, tx_din = '0, rx_data;
    logic       buf_full, overflow, start_seen, stop_seen, data_not_addr, read_mode;
    logic       addr_update, clk_released, irq;

    wire scl_line = !(m_scl_low || scl_oe);
    wire sda_line = !(m_sda_low || sda_oe);

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [10:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    i2c_addr_responder dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ten_bit_mode(ten_bit_mode),
        .gcall_en(gcall_en), .cond_irq_en(cond_irq_en), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr_wr(own_addr_wr), .own_addr_din(own_addr_din),
        .tx_wr(tx_wr), .tx_din(tx_din), .rx_rd(rx_rd), .rx_data(rx_data), .ovf_clr(ovf_clr),
        .clk_release(clk_release), .buf_full(buf_full), .overflow(overflow),
        .start_seen(start_seen), .stop_seen(stop_seen), .data_not_addr(data_not_addr),
        .read_mode(read_mode), .addr_update(addr_update), .clk_released(clk_released), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // scoreboard driver side: kind 0 = byte end {da, rw, rx}; kind 1 = condition {start, stop}
    task automatic expect_byte(input string tag, input logic d, input logic r, input logic [7:0] v);
        exp_q.push_back({1'b0, d, r, v});
        tag_q.push_back(tag);
    endtask

    task automatic expect_cond(input string tag, input logic s, input logic p);
        exp_q.push_back({1'b1, s, p, 8'h00});
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor side
    always @(negedge clk) begin
        if (rst_n && irq && !done) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R4/R11 unexpected irq: actual 1 expected 0");
            end else begin
                logic [10:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e[10])
                    chk(t, {start_seen, stop_seen}, e[9:8]);
                else
                    chk(t, {data_not_addr, read_mode, rx_data}, e[9:0]);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_scl_high();
        while (!scl_line) wait_cyc(1);
    endtask

    task automatic pulse(input int which);
        case (which)
            0: rx_rd = 1'b1;
            1: ovf_clr = 1'b1;
            2: clk_release = 1'b1;
            3: own_addr_wr = 1'b1;
            default: tx_wr = 1'b1;
        endcase
        wait_cyc(1);
        rx_rd = 1'b0; ovf_clr = 1'b0; clk_release = 1'b0; own_addr_wr = 1'b0; tx_wr = 1'b0;
        wait_cyc(2);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; m_scl_low = 1'b0;
        wait_cyc(H);
        m_sda_low = 1'b1;
        wait_cyc(H);
        m_scl_low = 1'b1;
        wait_cyc(H);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1;
        wait_cyc(H);
        m_scl_low = 1'b0;
        wait_scl_high();
        wait_cyc(H);
        m_sda_low = 1'b0;
        wait_cyc(H);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = !b[i];
            wait_cyc(H);
            m_scl_low = 1'b0;
            wait_scl_high();
            wait_cyc(H);
            m_scl_low = 1'b1;
            wait_cyc(H);
        end
        m_sda_low = 1'b0;
        wait_cyc(H);
        m_scl_low = 1'b0;
        wait_scl_high();
        wait_cyc(H);
        acked = !sda_line;
        m_scl_low = 1'b1;
        wait_cyc(H);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = 1'b0;
            wait_cyc(H);
            m_scl_low = 1'b0;
            wait_scl_high();
            wait_cyc(H);
            b[i] = sda_line;
            m_scl_low = 1'b1;
            wait_cyc(H);
        end
        m_sda_low = give_ack;
        wait_cyc(H);
        m_scl_low = 1'b0;
        wait_scl_high();
        wait_cyc(H);
        m_scl_low = 1'b1;
        wait_cyc(H);
        m_sda_low = 1'b0;
    endtask

    initial begin
        logic       ack;
        logic [7:0] rd;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        chk("reset scl_oe", scl_oe, 0);
        chk("reset sda_oe", sda_oe, 0);
        chk("reset flags", {buf_full, overflow, start_seen, stop_seen, read_mode, addr_update, irq}, 0);
        chk("reset clk_released", clk_released, 1);

        enable = 1'b1;
        own_addr_din = 8'h84;
        pulse(3);

        // write transfer, overflow
        bus_start();
        chk("R1 start_seen/stop_seen", {start_seen, stop_seen}, 2'b10);
        expect_byte("R6 address byte end", 1'b0, 1'b0, 8'h84);
        write_byte(8'h84, ack);
        chk("R3 address ack", ack, 1);
        chk("R6 buf_full after address", buf_full, 1);
        pulse(0);
        chk("R6 rx_rd clears buf_full", buf_full, 0);
        expect_byte("R6 data byte end", 1'b1, 1'b0, 8'h5A);
        write_byte(8'h5A, ack);
        chk("R6 data ack", ack, 1);
        expect_byte("R7 overflow byte end", 1'b1, 1'b0, 8'h5A);
        write_byte(8'hC3, ack);
        chk("R7 nack while full", ack, 0);
        chk("R7 overflow set", overflow, 1);
        chk("R7 rx_data kept", rx_data, 8'h5A);
        bus_stop();
        chk("R2 stop flags", {start_seen, stop_seen}, 2'b01);
        chk("R2 lines released", {scl_oe, sda_oe}, 2'b00);
        pulse(0);
        pulse(1);
        chk("R7 ovf_clr", overflow, 0);

        // address mismatch
        bus_start();
        write_byte(8'h90, ack);
        chk("R4 mismatch nack", ack, 0);
        write_byte(8'h11, ack);
        chk("R4 later byte nack", ack, 0);
        chk("R4 rx_data unchanged", rx_data, 8'h5A);
        bus_stop();

        // general call
        bus_start();
        write_byte(8'h00, ack);
        chk("R5 general call disabled", ack, 0);
        bus_stop();
        gcall_en = 1'b1;
        bus_start();
        expect_byte("R5 general call byte end", 1'b0, 1'b0, 8'h00);
        write_byte(8'h00, ack);
        chk("R5 general call ack", ack, 1);
        pulse(0);
        expect_byte("R5 general call data", 1'b1, 1'b0, 8'h77);
        write_byte(8'h77, ack);
        chk("R5 general call data ack", ack, 1);
        pulse(0);
        bus_stop();
        gcall_en = 1'b0;

        // read transfer
        bus_start();
        expect_byte("R8 read address byte end", 1'b0, 1'b1, 8'h85);
        write_byte(8'h85, ack);
        chk("R8 read address ack", ack, 1);
        chk("R8 read_mode/clk_released/buf_full", {read_mode, clk_released, buf_full}, 3'b100);
        m_scl_low = 1'b0;
        wait_cyc(40);
        chk("R8 clock held low", scl_line, 0);
        m_scl_low = 1'b1;
        tx_din = 8'h26;
        pulse(4);
        chk("R9 first bit presented", sda_line, 0);
        pulse(2);
        chk("R8 clk_release", scl_oe, 0);
        expect_byte("R9 sent byte acked", 1'b1, 1'b1, 8'h85);
        read_byte(1'b1, rd);
        chk("R9 first byte", rd, 8'h26);
        m_scl_low = 1'b0;
        wait_cyc(40);
        chk("R9 stretch after master ack", scl_line, 0);
        m_scl_low = 1'b1;
        tx_din = 8'hB5;
        pulse(4);
        pulse(2);
        expect_byte("R9 sent byte nacked", 1'b1, 1'b1, 8'h85);
        read_byte(1'b0, rd);
        chk("R9 second byte", rd, 8'hB5);
        wait_cyc(4);
        chk("R9 idle after master nack", {scl_oe, sda_oe}, 2'b00);
        bus_stop();

        // ten-bit addressing
        ten_bit_mode = 1'b1;
        own_addr_din = 8'hF2;
        pulse(3);
        bus_start();
        expect_byte("R10 first address byte", 1'b0, 1'b0, 8'hF2);
        write_byte(8'hF2, ack);
        chk("R10 first address ack", ack, 1);
        chk("R10 addr_update set", addr_update, 1);
        pulse(0);
        m_scl_low = 1'b0;
        wait_cyc(40);
        chk("R10 clock held low", scl_line, 0);
        m_scl_low = 1'b1;
        own_addr_din = 8'h35;
        pulse(3);
        chk("R10 address write releases", {addr_update, scl_oe}, 2'b00);
        expect_byte("R10 second address byte", 1'b0, 1'b0, 8'h35);
        write_byte(8'h35, ack);
        chk("R10 second address ack", ack, 1);
        chk("R10 addr_update again", addr_update, 1);
        pulse(0);
        own_addr_din = 8'hF2;
        pulse(3);
        expect_byte("R10 data byte", 1'b1, 1'b0, 8'h99);
        write_byte(8'h99, ack);
        chk("R10 data ack", ack, 1);
        pulse(0);
        bus_stop();
        ten_bit_mode = 1'b0;
        own_addr_din = 8'h84;
        pulse(3);

        // interrupt on bus conditions
        cond_irq_en = 1'b1;
        expect_cond("R11 irq on start", 1'b1, 1'b0);
        bus_start();
        expect_byte("R11 address byte end", 1'b0, 1'b0, 8'h84);
        write_byte(8'h84, ack);
        chk("R11 address ack", ack, 1);
        pulse(0);
        expect_cond("R11 irq on stop", 1'b0, 1'b1);
        bus_stop();
        cond_irq_en = 1'b0;

        wait_cyc(20);
        chk("R6 all predicted interrupts seen", exp_q.size(), 0);
        finish_run();
    end
endmodule